// File: doc/BRIEF.md
# Operand Effective Address Generator

This block forms the memory address of a data operand for a 32-bit processor core. It holds eight 32-bit address registers. Each request names a mode, one of the registers, an operand size and a displacement. The block answers one clock later with the effective address. In the auto-modify modes it also reports the new pointer value that it wrote into the register.

Two families of addressing are covered. The indexed family takes a slice of the register that depends on the operand size, zero-extends it, scales it by the operand size and adds a displacement of 16 or 32 bits. The auto-modify family uses the register as a pointer and steps it by the operand size. The four variants differ in direction (increment or decrement) and in whether the step is applied before or after the address is taken. The register file is updated on the same clock edge that presents the address, so a back-to-back request that names the same register sees the new value.

Top module: `opnd_addr_gen`

## Requirements
- R1: With mode code 0 (indexed), the address is the zero-extended index scaled by the operand size plus the extended displacement. The index is bits 7:0 of the register times 1 for size code 0 (byte), bits 15:0 times 2 for size code 1 (word), and all 32 bits times 4 for size code 2 (longword).
- R2: When `dispIsLong` is 0, only bits 15:0 of `dispValue` are used, sign-extended to 32 bits, and the upper bits are ignored. When `dispIsLong` is 1, all 32 bits are used.
- R3: With mode code 1 (post-increment), the address is the unmodified register value and the register becomes that value plus the step.
- R4: With mode code 2 (pre-decrement), the register value minus the step is both the address and the new register value.
- R5: With mode code 3 (pre-increment), the register value plus the step is both the address and the new register value.
- R6: With mode code 4 (post-decrement), the address is the unmodified register value and the register becomes that value minus the step.
- R7: The step and scale factor is 1 for size code 0, 2 for size code 1 and 4 for size code 2. Size code 3 behaves as longword.
- R8: `wbValid` pulses, with `wbReg` naming the register and `wbData` giving its new value, exactly when a valid auto-modify request was taken. An indexed request never changes any register.
- R9: `eaAddr` and `eaValid` appear on the clock edge after a valid request. The register update takes effect on that same edge, so a request on the very next cycle sees the updated value.
- R10: All address and pointer arithmetic wraps modulo 2^32.
- R11: A synchronous reset clears all eight registers to zero and holds `eaValid` and `wbValid` low.
- R12: Mode codes 5 to 7, and any cycle with `reqValid` low, produce no `eaValid`, no `wbValid` and no register change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Request strobe |
| reqMode | input | 3 | Addressing mode code |
| reqReg | input | 3 | Address register selector |
| reqSize | input | 2 | Operand size code |
| dispValue | input | 32 | Displacement |
| dispIsLong | input | 1 | 1: 32-bit displacement, 0: 16-bit sign-extended |
| eaAddr | output | 32 | Effective address |
| eaValid | output | 1 | Address valid pulse |
| wbValid | output | 1 | Register update pulse |
| wbReg | output | 3 | Register that was updated |
| wbData | output | 32 | New register value |

## Verification
Directed pre-decrements from the zero reset state drive registers to values just below 2^32. Indexed requests on those registers then give byte, word and longword slices that differ from one another, so a wrong slice, a wrong scale or a missing truncation shows up. Displacements with bit 15 set are tried with both width flags, and each flag yields a different sum. A long random walk mixes all eight mode codes, all four size codes and idle cycles, with most requests issued back to back. This separates pre-step from post-step ordering, exposes stale register reads, and catches any write-back from indexed or illegal requests when a register is later read through post-increment.

// File: rtl/eag_pkg.sv
package eag_pkg;

  typedef enum logic [2:0] {
    MODE_INDEX   = 3'd0,
    MODE_POSTINC = 3'd1,
    MODE_PREDEC  = 3'd2,
    MODE_PREINC  = 3'd3,
    MODE_POSTDEC = 3'd4
  } eaMode_e;

  typedef enum logic [1:0] {
    SIZE_BYTE = 2'd0,
    SIZE_WORD = 2'd1,
    SIZE_LONG = 2'd2,
    SIZE_RSVD = 2'd3
  } opSize_e;

  // strobes from control to datapath
  typedef struct packed {
    logic       fire;        // a legal request is accepted
    logic       writeBack;   // register file is updated
    logic       useIndex;    // address from scaled index + displacement
    logic       stepDown;    // pointer step subtracts
    logic       stepFirst;   // stepped pointer is the address
    logic [1:0] scaleShift;  // log2 of step / scale factor
  } eaCtrl_t;

endpackage

// File: rtl/eag_control.sv
module eag_control
  import eag_pkg::*;
(
  input  logic       reqValid,
  input  logic [2:0] reqMode,
  input  logic [1:0] reqSize,
  output eaCtrl_t    ctrl
);

  always_comb begin
    ctrl = '0;
    case (reqSize)
      SIZE_BYTE: ctrl.scaleShift = 2'd0;
      SIZE_WORD: ctrl.scaleShift = 2'd1;
      default:   ctrl.scaleShift = 2'd2;
    endcase
    if (reqValid) begin
      case (reqMode)
        MODE_INDEX: begin
          ctrl.fire     = 1'b1;
          ctrl.useIndex = 1'b1;
        end
        MODE_POSTINC: begin
          ctrl.fire      = 1'b1;
          ctrl.writeBack = 1'b1;
        end
        MODE_PREDEC: begin
          ctrl.fire      = 1'b1;
          ctrl.writeBack = 1'b1;
          ctrl.stepDown  = 1'b1;
          ctrl.stepFirst = 1'b1;
        end
        MODE_PREINC: begin
          ctrl.fire      = 1'b1;
          ctrl.writeBack = 1'b1;
          ctrl.stepFirst = 1'b1;
        end
        MODE_POSTDEC: begin
          ctrl.fire      = 1'b1;
          ctrl.writeBack = 1'b1;
          ctrl.stepDown  = 1'b1;
        end
        default: ctrl.fire = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/eag_datapath.sv
module eag_datapath
  import eag_pkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int NUM_REGS     = 8,
  parameter int SHORT_DISP_W = 16,
  localparam int SEL_W       = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  eaCtrl_t           ctrl,
  input  logic [SEL_W-1:0]  reqReg,
  input  logic [ADDR_W-1:0] dispValue,
  input  logic              dispIsLong,
  output logic [ADDR_W-1:0] eaAddr,
  output logic              eaValid,
  output logic              wbValid,
  output logic [SEL_W-1:0]  wbReg,
  output logic [ADDR_W-1:0] wbData
);

  localparam int BYTE_W = 8;
  localparam int HALF_W = 16;
  localparam int EXT_W  = ADDR_W - SHORT_DISP_W;

  logic [ADDR_W-1:0] regFile [NUM_REGS];
  logic [ADDR_W-1:0] baseVal;
  logic [ADDR_W-1:0] indexSlice;
  logic [ADDR_W-1:0] indexScaled;
  logic [ADDR_W-1:0] dispExt;
  logic [ADDR_W-1:0] stepAmt;
  logic [ADDR_W-1:0] steppedVal;
  logic [ADDR_W-1:0] addrNext;

  assign baseVal = regFile[reqReg];

  always_comb begin
    case (ctrl.scaleShift)
      2'd0:    indexSlice = {{(ADDR_W-BYTE_W){1'b0}}, baseVal[BYTE_W-1:0]};
      2'd1:    indexSlice = {{(ADDR_W-HALF_W){1'b0}}, baseVal[HALF_W-1:0]};
      default: indexSlice = baseVal;
    endcase
  end

  assign indexScaled = indexSlice << ctrl.scaleShift;
  assign dispExt     = dispIsLong ? dispValue
                     : {{EXT_W{dispValue[SHORT_DISP_W-1]}}, dispValue[SHORT_DISP_W-1:0]};
  assign stepAmt     = {{(ADDR_W-1){1'b0}}, 1'b1} << ctrl.scaleShift;
  assign steppedVal  = ctrl.stepDown ? (baseVal - stepAmt) : (baseVal + stepAmt);

  always_comb begin
    if (ctrl.useIndex)       addrNext = indexScaled + dispExt;
    else if (ctrl.stepFirst) addrNext = steppedVal;
    else                     addrNext = baseVal;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_REGS; i++) regFile[i] <= '0;
    end else if (ctrl.writeBack) begin
      regFile[reqReg] <= steppedVal;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      eaValid <= 1'b0;
      wbValid <= 1'b0;
      eaAddr  <= '0;
      wbReg   <= '0;
      wbData  <= '0;
    end else begin
      eaValid <= ctrl.fire;
      wbValid <= ctrl.writeBack;
      if (ctrl.fire) eaAddr <= addrNext;
      if (ctrl.writeBack) begin
        wbReg  <= reqReg;
        wbData <= steppedVal;
      end
    end
  end

endmodule

// File: rtl/opnd_addr_gen.sv
module opnd_addr_gen
  import eag_pkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int NUM_REGS     = 8,
  parameter int SHORT_DISP_W = 16,
  localparam int SEL_W       = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  input  logic [2:0]        reqMode,
  input  logic [SEL_W-1:0]  reqReg,
  input  logic [1:0]        reqSize,
  input  logic [ADDR_W-1:0] dispValue,
  input  logic              dispIsLong,
  output logic [ADDR_W-1:0] eaAddr,
  output logic              eaValid,
  output logic              wbValid,
  output logic [SEL_W-1:0]  wbReg,
  output logic [ADDR_W-1:0] wbData
);

  eaCtrl_t ctrl;

  eag_control i_ctrl (
    .reqValid (reqValid),
    .reqMode  (reqMode),
    .reqSize  (reqSize),
    .ctrl     (ctrl)
  );

  eag_datapath #(
    .ADDR_W       (ADDR_W),
    .NUM_REGS     (NUM_REGS),
    .SHORT_DISP_W (SHORT_DISP_W)
  ) i_dp (
    .clk        (clk),
    .rst        (rst),
    .ctrl       (ctrl),
    .reqReg     (reqReg),
    .dispValue  (dispValue),
    .dispIsLong (dispIsLong),
    .eaAddr     (eaAddr),
    .eaValid    (eaValid),
    .wbValid    (wbValid),
    .wbReg      (wbReg),
    .wbData     (wbData)
  );

endmodule

// File: rtl/eag_checker.sv
module eag_checker #(
  parameter int ADDR_W = 32,
  parameter int SEL_W  = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              reqValid,
  input logic [2:0]        reqMode,
  input logic [SEL_W-1:0]  reqReg,
  input logic [1:0]        reqSize,
  input logic [ADDR_W-1:0] eaAddr,
  input logic              eaValid,
  input logic              wbValid,
  input logic [SEL_W-1:0]  wbReg,
  input logic [ADDR_W-1:0] wbData
);

  function automatic logic [ADDR_W-1:0] stepOf(input logic [1:0] sz);
    case (sz)
      2'd0:    return ADDR_W'(1);
      2'd1:    return ADDR_W'(2);
      default: return ADDR_W'(4);
    endcase
  endfunction

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!eaValid && !wbValid)); // R11

  AST_LEGAL_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (reqValid && reqMode <= 3'd4) |=> eaValid); // R9

  AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!reqValid || reqMode > 3'd4) |=> (!eaValid && !wbValid)); // R12

  AST_INDEX_NO_WB: assert property (@(posedge clk) disable iff (rst)
    (reqValid && reqMode == 3'd0) |=> !wbValid); // R8

  AST_WB_REG_MATCH: assert property (@(posedge clk) disable iff (rst)
    (reqValid && reqMode inside {3'd1, 3'd2, 3'd3, 3'd4}) |=> (wbValid && wbReg == $past(reqReg))); // R8

  AST_POSTINC_STEP: assert property (@(posedge clk) disable iff (rst)
    (reqValid && reqMode == 3'd1) |=> (wbData - eaAddr == stepOf($past(reqSize)))); // R3

  AST_PREDEC_SAME: assert property (@(posedge clk) disable iff (rst)
    (reqValid && reqMode == 3'd2) |=> (wbData == eaAddr)); // R4

  AST_PREINC_SAME: assert property (@(posedge clk) disable iff (rst)
    (reqValid && reqMode == 3'd3) |=> (wbData == eaAddr)); // R5

  AST_POSTDEC_STEP: assert property (@(posedge clk) disable iff (rst)
    (reqValid && reqMode == 3'd4) |=> (eaAddr - wbData == stepOf($past(reqSize)))); // R6

endmodule

bind opnd_addr_gen eag_checker #(.ADDR_W(ADDR_W), .SEL_W(SEL_W)) i_chk (.*);

// File: tb/test_opnd_addr_gen.sv
`timescale 1ns/1ps
module test_opnd_addr_gen;

  logic        clk = 1'b0;
  logic        rst;
  logic        reqValid;
  logic [2:0]  reqMode;
  logic [2:0]  reqReg;
  logic [1:0]  reqSize;
  logic [31:0] dispValue;
  logic        dispIsLong;
  logic [31:0] eaAddr;
  logic        eaValid;
  logic        wbValid;
  logic [2:0]  wbReg;
  logic [31:0] wbData;

  int checks   = 0;
  int failures = 0;
  logic [31:0] model [8];

  always #4 clk = ~clk;

  opnd_addr_gen i_opnd_addr_gen (.*);

  function automatic logic [31:0] stepOf(input logic [1:0] sz);
    return (sz == 2'd0) ? 32'd1 : (sz == 2'd1) ? 32'd2 : 32'd4;
  endfunction

  function automatic logic [31:0] idxOf(input logic [31:0] r, input logic [1:0] sz);
    if (sz == 2'd0) return {24'd0, r[7:0]};
    if (sz == 2'd1) return {15'd0, r[15:0], 1'b0};
    return {r[29:0], 2'b00};
  endfunction

  function automatic logic [31:0] dispOf(input logic [31:0] d, input logic isLong);
    return isLong ? d : {{16{d[15]}}, d[15:0]};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one request; result checked after the next rising edge
  task automatic issue(input bit v, input logic [2:0] m, input logic [2:0] r,
                       input logic [1:0] s, input logic [31:0] d, input bit lg);
    logic [31:0] b, ea, nw;
    bit legal, wb;
    @(negedge clk);
    reqValid = v; reqMode = m; reqReg = r; reqSize = s; dispValue = d; dispIsLong = lg;
    b = model[r];
    legal = v && (m <= 3'd4);
    wb = legal && (m != 3'd0);
    nw = (m == 3'd2 || m == 3'd4) ? b - stepOf(s) : b + stepOf(s);
    case (m)
      3'd0:        ea = idxOf(b, s) + dispOf(d, lg);  // R1 R2
      3'd2, 3'd3:  ea = nw;                           // R4 R5
      default:     ea = b;                            // R3 R6
    endcase
    @(posedge clk);
    #1;
    check(eaValid == legal, legal ? "R9 eaValid" : "R12 eaValid", 32'(eaValid), 32'(legal));
    check(wbValid == wb, "R8 wbValid", 32'(wbValid), 32'(wb));
    if (legal) check(eaAddr == ea, m == 3'd0 ? "R1 index addr" : "R7 step addr", eaAddr, ea);
    if (wb) begin
      check(wbData == nw && wbReg == r, "R10 wbData", wbData, nw);
      model[r] = nw;
    end
  endtask

  initial begin
    #(8ns * 200000);
    failures++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 8; i++) model[i] = '0;
    rst = 1'b1; reqValid = 1'b0; reqMode = '0; reqReg = '0; reqSize = '0;
    dispValue = '0; dispIsLong = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check(!eaValid && !wbValid, "R11 reset outputs", 32'({eaValid, wbValid}), 32'd0);
    @(negedge clk); rst = 1'b0;

    // R4 R10: pre-decrement from zero wraps
    issue(1, 3'd2, 3'd0, 2'd2, 32'd0, 0);
    check(eaAddr == 32'hFFFF_FFFC, "R4 predec wrap", eaAddr, 32'hFFFF_FFFC);
    // R1 R2: slices and short displacement with bit 15 set
    issue(1, 3'd0, 3'd0, 2'd0, 32'h1234_8000, 0);
    check(eaAddr == 32'hFFFF_80FC, "R2 short disp", eaAddr, 32'hFFFF_80FC);
    issue(1, 3'd0, 3'd0, 2'd0, 32'h1234_8000, 1);
    check(eaAddr == 32'h1234_80FC, "R2 long disp", eaAddr, 32'h1234_80FC);
    issue(1, 3'd0, 3'd0, 2'd1, 32'h0000_0010, 0);
    check(eaAddr == 32'h0002_0008, "R1 word index", eaAddr, 32'h0002_0008);
    issue(1, 3'd0, 3'd0, 2'd2, 32'h0000_0020, 1);
    check(eaAddr == 32'h0000_0010, "R1 long index", eaAddr, 32'h0000_0010);
    // R3 R10: post-increment reads unchanged value, wraps to zero
    issue(1, 3'd1, 3'd0, 2'd3, 32'd0, 0);
    check(eaAddr == 32'hFFFF_FFFC && wbData == 32'd0, "R3 postinc wrap", wbData, 32'd0);
    // R5 R6 R9: back-to-back on one register
    issue(1, 3'd3, 3'd1, 2'd1, 32'd0, 0);
    check(eaAddr == 32'd2, "R5 preinc", eaAddr, 32'd2);
    issue(1, 3'd4, 3'd1, 2'd0, 32'd0, 0);
    check(eaAddr == 32'd2 && wbData == 32'd1, "R6 postdec", wbData, 32'd1);
    issue(1, 3'd1, 3'd1, 2'd0, 32'd0, 0);
    check(eaAddr == 32'd1, "R9 back-to-back", eaAddr, 32'd1);
    // R12: illegal mode and idle leave register 2 untouched
    issue(1, 3'd5, 3'd2, 2'd2, 32'd0, 0);
    issue(0, 3'd1, 3'd2, 2'd2, 32'd0, 0);
    issue(1, 3'd1, 3'd2, 2'd2, 32'd0, 0);
    check(eaAddr == 32'd0, "R12 no change", eaAddr, 32'd0);

    for (int n = 0; n < 4000; n++) begin
      issue(($urandom % 8) != 0, 3'($urandom), 3'($urandom), 2'($urandom),
            $urandom, 1'($urandom));
    end
    for (int i = 0; i < 8; i++) issue(1, 3'd1, 3'(i), 2'd0, 32'd0, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule